// File: doc/BRIEF.md
# Majority-Vote Word Receiver

This block takes a sliced, one-bit, Manchester-coded control-channel signal and turns it into checked data words. The line is oversampled eight times per bit cell, and each cell is decoded into a bit. The sampling phase re-aligns on every mid-cell transition, so slow drift between the two ends does no harm. A host-supplied framing pulse marks the start of each 40-bit copy. Every word is sent five times. The block accumulates the copies and forms each output bit as the 3-of-5 majority of the five received values. The voted word is then checked against its 12-bit cyclic parity.

A standby input turns the voting off to save activity. The copy that has just completed is then handed to the parity check directly, and the rest of the word's copies are dropped. The result is kept on the outputs until the host acknowledges it. A word that completes while an earlier result is still unacknowledged is discarded, and an overrun flag records the loss.

Top module: `mvr_word_rx`

## Requirements
- R1: A bit cell is decoded as 1 when its first half is high and its second half is low, and as 0 for the opposite order. Each cell is sampled 8 times, at a sample rate of the clock divided by SAMPLE_DIV. Cell timing restarts on `frame_sync`.
- R2: A copy whose whole bit stream arrives one sample later than the framing pulse predicts is still decoded correctly, because the cell phase re-aligns to each mid-cell transition.
- R3: A copy is 40 bits, and the first bit received is bit 39. Bits 39..12 are the 28 data bits (`word_data[27:0]`) and bits 11..0 are the parity.
- R4: `frame_sync` together with `first_copy` = 1 starts a new word. A `frame_sync` with `first_copy` = 0 while no word is in progress is ignored.
- R5: With `standby` = 0, no result appears before the fifth copy completes. Each bit of the result is 1 exactly when at least 3 of the 5 copies carry a 1 there.
- R6: With `standby` = 1, the first copy is used unvoted and the result appears after it. The remaining copies of that word produce no result and no overrun.
- R7: The parity is the remainder of data·x^12 divided by g(x) = x^12+x^10+x^8+x^5+x^4+x^3+1, with data bit 27 as the highest power. `word_err` = 1 when the received parity differs from it.
- R8: When a result is ready, `word_valid` goes to 1. `word_data` and `word_err` then hold until `ack`.
- R9: A word that completes while `word_valid` = 1 and `ack` = 0 sets `overrun` = 1 and leaves the held result unchanged.
- R10: `ack` clears `word_valid` and `overrun`. An `ack` while no result is held changes nothing.
- R11: After reset, `word_valid`, `word_err` and `overrun` are 0 and `word_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Sliced Manchester line signal |
| frame_sync | input | 1 | One-cycle pulse at the start of each copy |
| first_copy | input | 1 | Marks the copy begun by this pulse as the first of a word |
| standby | input | 1 | 1: skip voting and use a single copy |
| ack | input | 1 | Host acknowledge of the held result |
| word_valid | output | 1 | A result is held |
| word_data | output | 28 | Data bits of the result |
| word_err | output | 1 | Parity mismatch in the result |
| overrun | output | 1 | A word was dropped while a result was held |

## Verification
The vote is driven to its boundary: two corrupted copies out of five must be voted away, and three corrupted copies must win. A design with the threshold off by one would pass the wrong word, or flag a parity error on a clean one. Standby words are followed by four deliberately corrupted copies; a design that kept listening would report an overrun or replace the word. Further cases cover a one-sample-late stream, a start pulse without the first-copy mark, and a second word arriving before the acknowledge. These catch a decoder that loses cell alignment, a receiver that starts mid-word, and an output stage that overwrites an unread result.

// File: rtl/mvr_pkg.sv
// Shared sizes and the parity generator for the majority-vote word receiver.
package mvr_pkg;
    localparam int WORD_W   = 40;              // bits per copy
    localparam int PAR_W    = 12;              // parity bits at the tail
    localparam int DATA_W   = WORD_W - PAR_W;  // data bits at the head
    localparam int COPIES   = 5;               // repetitions per word
    localparam int VOTE_MIN = 3;               // ones needed to vote a 1
    localparam int OSR      = 8;               // samples per bit cell
    localparam int CNT_W    = $clog2(COPIES + 1);
    localparam int REP_W    = $clog2(COPIES);
    localparam int BIT_W    = $clog2(WORD_W + 1);
    localparam logic [PAR_W-1:0] GEN_POLY = 12'h539; // g(x) without x^12

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/mvr_line_decoder.sv
// Manchester cell decoder: synchronises the line, takes OSR samples per cell
// and emits one bit per cell (value = first-half level).
// Assumes: cell_start is a one-cycle pulse aligned to a cell boundary,
// SAMPLE_DIV >= 2, and at most a one-sample phase error per cell.
module mvr_line_decoder #(
    parameter int SAMPLE_DIV = 1250,
    parameter int OSR        = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic cell_start,
    output logic bit_vld,
    output logic bit_val
);
    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam int PH_W  = $clog2(OSR);
    localparam int MID   = OSR / 2;
    localparam logic [PH_W-1:0]  PH_CAP = PH_W'(MID / 2);
    localparam logic [PH_W-1:0]  PH_LO  = PH_W'(MID - 1);
    localparam logic [PH_W-1:0]  PH_HI  = PH_W'(MID + 1);
    localparam logic [PH_W-1:0]  PH_END = PH_W'(OSR - 1);
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(SAMPLE_DIV - 1);

    logic [1:0]       rx_meta;
    logic             rx_s, prev_s, half_lvl, cell_done;
    logic [DIV_W-1:0] div_cnt;
    logic [PH_W-1:0]  phase;
    logic             tick, lvl_chg, in_win, take_edge, emit;

    assign rx_s      = rx_meta[1];
    assign tick      = (div_cnt == DIV_END) && !cell_start;
    assign lvl_chg   = rx_s != prev_s;
    assign in_win    = (phase >= PH_LO) && (phase <= PH_HI);
    assign take_edge = tick && in_win && lvl_chg && !cell_done;
    assign emit      = take_edge || (tick && phase == PH_HI && !cell_done);

    // Two-stage synchroniser for the asynchronous line input.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_meta <= '0;
        else        rx_meta <= {rx_meta[0], rx_in};
    end

    // Sample divider, cell phase, first-half capture and re-centring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt   <= '0;
            phase     <= '0;
            prev_s    <= 1'b0;
            half_lvl  <= 1'b0;
            cell_done <= 1'b0;
        end else if (cell_start) begin
            div_cnt   <= '0;
            phase     <= '0;
            cell_done <= 1'b0;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) begin
                prev_s <= rx_s;
                if (phase == PH_CAP) half_lvl <= rx_s;
                phase <= take_edge ? PH_HI : phase + 1'b1;
                if (emit)               cell_done <= 1'b1;
                else if (phase == PH_END) cell_done <= 1'b0;
            end
        end
    end

    // Registered bit output, one pulse per cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_vld <= 1'b0;
            bit_val <= 1'b0;
        end else begin
            bit_vld <= emit;
            if (emit) bit_val <= half_lvl;
        end
    end

    AST_ONE_BIT_PER_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld); // R1
endmodule

// File: rtl/mvr_vote_bank.sv
// Copy assembler and per-bit vote: shifts in each 40-bit copy, adds it into
// one ones-counter per bit, and flags the word done after the last copy
// (or after any copy while standby is high, passing that copy through).
// Assumes: frame_sync is not coincident with the completion of a copy.
module mvr_vote_bank
    import mvr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_sync,
    input  logic  first_copy,
    input  logic  standby,
    input  logic  bit_vld,
    input  logic  bit_val,
    output logic  word_done,
    output word_t voted
);
    logic             active, rep_full, last_copy;
    logic [REP_W-1:0] rep_idx;
    logic [BIT_W-1:0] bit_cnt;
    word_t            shreg;
    logic [CNT_W-1:0] ones [WORD_W];

    assign last_copy = standby || (rep_idx == REP_W'(COPIES - 1));
    assign word_done = rep_full && last_copy;

    // Copy sequencing: start, bit shifting, copy completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            rep_idx  <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            rep_full <= 1'b0;
        end else begin
            rep_full <= 1'b0;
            if (rep_full) begin
                if (last_copy) active  <= 1'b0;
                else           rep_idx <= rep_idx + 1'b1;
            end
            if (frame_sync) begin
                bit_cnt <= '0;
                if (first_copy) begin
                    active  <= 1'b1;
                    rep_idx <= '0;
                end
            end else if (active && bit_vld && bit_cnt < BIT_W'(WORD_W)) begin
                shreg   <= {shreg[WORD_W-2:0], bit_val};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(WORD_W - 1)) rep_full <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        logic [CNT_W-1:0] sum;
        assign sum      = ones[i] + CNT_W'(shreg[i]);
        assign voted[i] = standby ? shreg[i] : (sum >= CNT_W'(VOTE_MIN));

        // Ones counter for this bit position across the copies of a word.
        always_ff @(posedge clk) begin
            if (!rst_n)                       ones[i] <= '0;
            else if (frame_sync && first_copy) ones[i] <= '0;
            else if (rep_full)                ones[i] <= sum;
        end
    end

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BIT_W'(WORD_W)); // R3
    AST_DONE_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(bit_cnt) == BIT_W'(WORD_W - 1)); // R5
endmodule

// File: rtl/mvr_code_check.sv
// Parity check: recomputes the 12-bit cyclic parity of the data field with a
// bit-serial LFSR unrolled over the data bits and compares it with the tail.
// Assumes: data occupies the high bits, most significant bit sent first.
module mvr_code_check
    import mvr_pkg::*;
(
    input  word_t             word,
    output logic [DATA_W-1:0] data,
    output logic              err
);
    // Remainder of d(x)*x^PAR_W modulo the generator.
    function automatic logic [PAR_W-1:0] calc_par(input logic [DATA_W-1:0] d);
        logic [PAR_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = d[i] ^ r[PAR_W-1];
            r  = {r[PAR_W-2:0], 1'b0} ^ (fb ? GEN_POLY : '0);
        end
        return r;
    endfunction

    assign data = word[WORD_W-1:PAR_W];
    assign err  = calc_par(data) != word[PAR_W-1:0];
endmodule

// File: rtl/mvr_word_rx.sv
// Top: line decoder -> copy vote -> parity check -> held result with
// acknowledge and overrun. Assumes ack is a synchronous pulse from the host.
module mvr_word_rx
    import mvr_pkg::*;
#(
    parameter int SAMPLE_DIV = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              frame_sync,
    input  logic              first_copy,
    input  logic              standby,
    input  logic              ack,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic              word_err,
    output logic              overrun
);
    logic              bit_vld, bit_val, word_done, chk_err;
    word_t             voted;
    logic [DATA_W-1:0] chk_data;

    mvr_line_decoder #(.SAMPLE_DIV(SAMPLE_DIV), .OSR(OSR)) u_dec (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cell_start(frame_sync),
        .bit_vld(bit_vld), .bit_val(bit_val)
    );

    mvr_vote_bank u_vote (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .first_copy(first_copy), .standby(standby), .bit_vld(bit_vld),
        .bit_val(bit_val), .word_done(word_done), .voted(voted)
    );

    mvr_code_check u_chk (.word(voted), .data(chk_data), .err(chk_err));

    // Result holding register with acknowledge and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_err   <= 1'b0;
            overrun    <= 1'b0;
        end else if (word_done && word_valid && !ack) begin
            overrun <= 1'b1;
        end else if (word_done) begin
            word_valid <= 1'b1;
            word_data  <= chk_data;
            word_err   <= chk_err;
            overrun    <= 1'b0;
        end else if (ack) begin
            word_valid <= 1'b0;
            overrun    <= 1'b0;
        end
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !ack |=> word_valid && $stable(word_data) && $stable(word_err)); // R8
    AST_OVR_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(word_valid)); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && ack && !word_done |=> !word_valid && !overrun); // R10
endmodule

// File: tb/mvr_word_rx_test.sv
module mvr_word_rx_test;
    localparam int DIV = 4;
    localparam int SPH = 4 * DIV; // clocks per half cell

    // {data[86:59], parity flip[58:47], bad-copy mask[46:42],
    //  error pattern[41:2], standby[1], one-sample delay[0]}
    localparam logic [86:0] VECS [0:6] = '{
        {28'h0000000, 12'h000, 5'b00000, 40'h0000000000, 1'b0, 1'b0},
        {28'hA5C3F10, 12'h000, 5'b00011, 40'h00F0000001, 1'b0, 1'b0},
        {28'h1234567, 12'h000, 5'b10101, 40'h0000000100, 1'b0, 1'b0},
        {28'hFFFFFFF, 12'h001, 5'b00000, 40'h0000000000, 1'b0, 1'b0},
        {28'h0F0F0F0, 12'h000, 5'b00001, 40'h8000000000, 1'b1, 1'b0},
        {28'h7654321, 12'h000, 5'b11110, 40'hFFFFFFFFFF, 1'b1, 1'b0},
        {28'h5555555, 12'h000, 5'b11000, 40'hFFFFFFFFFF, 1'b0, 1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, rx_in = 1'b0;
    logic        frame_sync = 1'b0, first_copy = 1'b0, standby = 1'b0, ack = 1'b0;
    logic        word_valid, word_err, overrun;
    logic [27:0] word_data;
    int          compared = 0, mismatched = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    mvr_word_rx #(.SAMPLE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .frame_sync(frame_sync),
        .first_copy(first_copy), .standby(standby), .ack(ack),
        .word_valid(word_valid), .word_data(word_data), .word_err(word_err),
        .overrun(overrun)
    );

    function automatic logic [11:0] ref_par(input logic [27:0] d);
        logic [39:0] v;
        v = {d, 12'b0};
        for (int i = 39; i >= 12; i--)
            if (v[i]) v = v ^ (40'h1539 << (i - 12));
        return v[11:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_copy(input logic [39:0] w, input logic first, input logic late);
        @(negedge clk);
        frame_sync = 1'b1;
        first_copy = first;
        if (late) begin
            rx_in = 1'b0;
            repeat (DIV) begin @(negedge clk); frame_sync = 1'b0; end
        end
        for (int b = 39; b >= 0; b--)
            for (int h = 0; h < 2; h++) begin
                rx_in = (h == 0) ? w[b] : ~w[b];
                repeat (SPH) begin @(negedge clk); frame_sync = 1'b0; end
            end
        rx_in = 1'b0;
        first_copy = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [39:0] cp [5];
        logic [39:0] vt;
        logic [39:0] wa, wb;
        logic [86:0] v;
        int          ones;

        repeat (5) @(negedge clk);
        chk("R11 valid", word_valid, 0);
        chk("R11 err", word_err, 0);
        chk("R11 overrun", overrun, 0);
        chk("R11 data", word_data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4: start pulse without the first-copy mark is ignored
        standby = 1'b1;
        send_copy({28'h1111111, ref_par(28'h1111111)}, 1'b0, 1'b0);
        chk("R4 no word from unmarked start", word_valid, 0);

        foreach (VECS[n]) begin
            v = VECS[n];
            standby = v[1];
            for (int c = 0; c < 5; c++)
                cp[c] = {v[86:59], ref_par(v[86:59]) ^ v[58:47]} ^ (v[42 + c] ? v[41:2] : 40'h0);
            for (int i = 0; i < 40; i++) begin
                ones = 0;
                for (int c = 0; c < 5; c++) ones += int'(cp[c][i]);
                vt[i] = ones >= 3;
            end
            if (v[1]) vt = cp[0];
            for (int c = 0; c < 5; c++) begin
                send_copy(cp[c], c == 0, v[0]);
                if (c == 3 && !v[1]) chk("R5 nothing before fifth copy", word_valid, 0);
            end
            chk(v[1] ? "R6 word ready" : "R5 word ready", word_valid, 1);
            chk(v[0] ? "R2 late stream data" : "R1 R3 R5 R6 data", word_data, vt[39:12]);
            chk("R7 parity flag", word_err, ref_par(vt[39:12]) != vt[11:0]);
            chk(v[1] ? "R6 extra copies ignored" : "R9 no overrun", overrun, 0);
            pulse_ack();
            chk("R10 ack clears", word_valid, 0);
        end

        // R8 / R9: second word before acknowledge
        standby = 1'b1;
        wa = {28'hC0FFEE1, ref_par(28'hC0FFEE1)};
        wb = {28'h0BADF00, ref_par(28'h0BADF00) ^ 12'h800};
        send_copy(wa, 1'b1, 1'b0);
        repeat (100) @(negedge clk);
        chk("R8 still held", word_valid, 1);
        chk("R8 data held", word_data, 28'hC0FFEE1);
        send_copy(wb, 1'b1, 1'b0);
        chk("R9 overrun set", overrun, 1);
        chk("R9 old data kept", word_data, 28'hC0FFEE1);
        chk("R9 old err kept", word_err, 0);
        pulse_ack();
        chk("R10 valid cleared", word_valid, 0);
        chk("R10 overrun cleared", overrun, 0);
        pulse_ack();
        chk("R10 idle ack no effect valid", word_valid, 0);
        chk("R10 idle ack no effect overrun", overrun, 0);
        send_copy(wb, 1'b1, 1'b0);
        chk("R7 parity error flagged", word_err, 1);
        chk("R3 data field", word_data, 28'h0BADF00);

        finish_run();
    end
endmodule